// File: doc/BRIEF.md
# Two-Phase Set-Associative Cache Read Path

This block is the read side of a four-way set-associative cache. It splits every lookup into two clock cycles. In the first cycle it reads and compares the tags of all ways in the addressed set. In the second cycle it reads the data array of the single way whose tag matched. Because the other data ways are never read, each hit costs four tag reads and one data read instead of four of each. The price is one extra cycle of latency compared with reading tags and data side by side.

Requests come in on a valid/ready handshake with a byte-free word address. Responses come back as a one-cycle pulse that carries a hit flag and the addressed word. The block exposes its per-way tag-read and data-read enables so that the energy behaviour can be observed from outside. The line storage is internal. A fill port writes a whole line, with its tag, into a chosen way, or clears the valid bit of that way. Replacement choice, write-back and miss handling belong to the surrounding logic.

Top module: `phased_cache_lookup`

## Requirements
- R1: The request address is split into three fields. Bits [OFF_W-1:0] select the word within the line (word k occupies line bits [k*DATA_W +: DATA_W]). The next IDX_W bits select the set. The remaining upper bits form the tag. A line only answers for addresses with its own set and tag.
- R2: In the cycle after a request is accepted (the tag phase), `tag_rd_en` is all ones and `data_way_en` is zero. In every other cycle, `tag_rd_en` is zero.
- R3: When the tag phase finds a match, the next cycle is the data phase. In it, `data_way_en` is one-hot with the bit of the matching way set. At the end of that cycle `rsp_valid` pulses with `rsp_hit`=1 and the addressed word on `rsp_data`. The response is visible two clock edges after the accepting edge.
- R4: When the tag phase finds no match, `rsp_valid` pulses with `rsp_hit`=0 and `rsp_data`=0 one clock edge after the accepting edge. No bit of `data_way_en` is raised for that lookup.
- R5: A way whose valid bit is clear never matches, even if its stored tag equals the request tag.
- R6: `req_ready` is low throughout the data phase, and also during a tag phase that matches. It is high when idle and during a tag phase that misses. In the latter case a new request can be accepted on the same edge that produces the miss response.
- R7: After reset, every line is invalid, `req_ready` is high, and `rsp_valid`, `tag_rd_en` and `data_way_en` are zero.
- R8: A clock edge with `fill_valid` high and `fill_clear` low stores `fill_line` and the tag of `fill_addr` into way `fill_way` of the set given by `fill_addr`, and marks that way valid. With `fill_clear` high, it only clears that way's valid bit. Other ways and sets are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the lookup |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response is a hit |
| rsp_data | output | DATA_W | Addressed word on a hit, zero on a miss |
| tag_rd_en | output | WAYS | Per-way tag array read enable |
| data_way_en | output | WAYS | Per-way data array read enable |
| fill_valid | input | 1 | Perform a fill or invalidate this cycle |
| fill_clear | input | 1 | Invalidate instead of writing |
| fill_way | input | WAY_W | Target way |
| fill_addr | input | ADDR_W | Address giving set and tag of the line |
| fill_line | input | WORDS*DATA_W | Line contents |

## Verification
The hardest case to reach is a way that is invalid but still holds a tag equal to the request tag. The stimulus fills a way and then clears it through the invalidate path, which leaves the stale tag in place. It then looks up that exact address and checks that neither a hit nor any data enable appears. A second hard case is a request accepted during a missing tag phase. The bench holds `req_valid` high across the first lookup's tag cycle, so that the miss response and the second tag phase fall on the same edge. It also holds a request pending through a hit's data phase and checks that the request is taken only once the block is idle.

// File: rtl/phased_cache_lookup.sv
module phased_cache_lookup #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  localparam int WAY_W = $clog2(WAYS),
  localparam int WORDS = 1 << OFF_W,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic [WAYS-1:0]   tag_rd_en,
  output logic [WAYS-1:0]   data_way_en,
  input  logic              fill_valid,
  input  logic              fill_clear,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [LINE_W-1:0] fill_line
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  typedef enum logic [1:0] {ST_IDLE, ST_TAG, ST_DATA} phase_t;

  phase_t            st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WAY_W-1:0]  way_q;
  logic              rsp_valid_q, rsp_hit_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
  logic [LINE_W-1:0] line_mem [SETS][WAYS];
  logic [WAYS-1:0]   vld_mem  [SETS];

  logic [TAG_W-1:0] cur_tag;
  logic [IDX_W-1:0] cur_set, fill_set;
  logic [OFF_W-1:0] cur_off;
  logic [WAYS-1:0]  match;
  logic             any_match;
  logic [WAY_W-1:0] hit_way;
  logic [LINE_W-1:0] sel_line;
  logic [DATA_W-1:0] sel_word;
  logic             accept;

  assign cur_tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign cur_set  = addr_q[OFF_W +: IDX_W];
  assign cur_off  = addr_q[OFF_W-1:0];
  assign fill_set = fill_addr[OFF_W +: IDX_W];

  // phase one: every way's tag is compared, gated by its valid bit
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = tag_rd_en[w] && vld_mem[cur_set][w] && (tag_mem[cur_set][w] == cur_tag);
  end
  assign any_match = |match;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WAY_W'(w);
  end

  assign tag_rd_en   = {WAYS{st_q == ST_TAG}};
  assign data_way_en = (st_q == ST_DATA) ? (WAYS'(1) << way_q) : '0;

  // phase two: only the enabled way feeds the word mux
  always_comb begin
    sel_line = '0;
    for (int w = 0; w < WAYS; w++)
      if (data_way_en[w]) sel_line = line_mem[cur_set][w];
  end
  assign sel_word = sel_line[cur_off*DATA_W +: DATA_W];

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_TAG && !any_match);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      way_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_TAG;
          addr_q <= req_addr;
        end
        ST_TAG: if (any_match) begin
          st_q  <= ST_DATA;
          way_q <= hit_way;
        end else begin
          rsp_valid_q <= 1'b1;
          rsp_hit_q   <= 1'b0;
          rsp_data_q  <= '0;
          if (accept) begin
            st_q   <= ST_TAG;
            addr_q <= req_addr;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_DATA: begin
          rsp_valid_q <= 1'b1;
          rsp_hit_q   <= 1'b1;
          rsp_data_q  <= sel_word;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_data  = rsp_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
    end else if (fill_valid) begin
      vld_mem[fill_set][fill_way] <= !fill_clear;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid && !fill_clear) begin
      tag_mem[fill_set][fill_way]  <= fill_addr[ADDR_W-1 -: TAG_W];
      line_mem[fill_set][fill_way] <= fill_line;
    end
  end

  AST_TAG_DATA_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !((|tag_rd_en) && (|data_way_en))); // R2
  AST_DATA_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_way_en)); // R3
  AST_DATA_AFTER_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|data_way_en) |-> $past(tag_rd_en) == {WAYS{1'b1}}); // R3
  AST_HIT_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|data_way_en) |=> (rsp_valid && rsp_hit)); // R3
  AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> ($past(tag_rd_en) == {WAYS{1'b1}} && $past(data_way_en) == '0)); // R4
  AST_NO_ACCEPT_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (|data_way_en) |-> !req_ready); // R6
endmodule

// File: tb/phased_cache_lookup_tb_top.sv
module phased_cache_lookup_tb_top;
  localparam int ADDR_W = 16, DATA_W = 32, WAYS = 4, WAY_W = 2, LINE_W = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, fill_valid = 1'b0, fill_clear = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0, fill_addr = '0;
  logic [WAY_W-1:0] fill_way = '0;
  logic [LINE_W-1:0] fill_line = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [DATA_W-1:0] rsp_data;
  logic [WAYS-1:0] tag_rd_en, data_way_en;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  phased_cache_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .tag_rd_en(tag_rd_en), .data_way_en(data_way_en), .fill_valid(fill_valid),
    .fill_clear(fill_clear), .fill_way(fill_way), .fill_addr(fill_addr), .fill_line(fill_line));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
    return {tag[9:0], set[3:0], off[1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] word_of(input int set, input int way, input int gen, input int k);
    return {gen[7:0], way[3:0], set[3:0], k[7:0], 8'hA5};
  endfunction

  function automatic logic [LINE_W-1:0] line_of(input int set, input int way, input int gen);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < 4; k++) l[k*DATA_W +: DATA_W] = word_of(set, way, gen, k);
    return l;
  endfunction

  task automatic fill(input int tag, input int set, input int way, input int gen, input bit clr);
    @(negedge clk);
    fill_valid = 1'b1; fill_clear = clr; fill_way = WAY_W'(way);
    fill_addr = mk(tag, set, 0); fill_line = line_of(set, way, gen);
    @(negedge clk);
    fill_valid = 1'b0; fill_clear = 1'b0;
  endtask

  task automatic lookup(input int tag, input int set, input int off, input bit exp_hit,
                        input int way, input int gen, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(tag, set, off);
    chk(req_ready === 1'b1, "R6 ready idle", 64'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag_rd_en === 4'hF && data_way_en === 4'h0, "R2 tag phase",
        64'({tag_rd_en, data_way_en}), 64'h F0);
    chk(req_ready === !exp_hit, "R6 ready in tag phase", 64'(req_ready), 64'(!exp_hit));
    @(negedge clk);
    if (exp_hit) begin
      chk(data_way_en === 4'(1 << way) && tag_rd_en === 4'h0, {req, " data phase enable"},
          64'(data_way_en), 64'(1 << way));
      chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R6 ready low in data phase",
          64'({req_ready, rsp_valid}), 0);
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_hit === 1'b1 && rsp_data === word_of(set, way, gen, off),
          {req, " hit response"}, 64'({rsp_valid, rsp_hit, rsp_data}),
          64'({2'b11, word_of(set, way, gen, off)}));
    end else begin
      chk(rsp_valid === 1'b1 && rsp_hit === 1'b0 && rsp_data === '0 && data_way_en === 4'h0,
          {req, " miss response"}, 64'({rsp_valid, rsp_hit, data_way_en, rsp_data}), 64'({2'b10, 4'h0, 32'h0}));
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R3 response is a single pulse", 64'(rsp_valid), 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && tag_rd_en === 4'h0 && data_way_en === 4'h0,
        "R7 reset outputs", 64'({req_ready, rsp_valid, tag_rd_en, data_way_en}), 64'h200);
    lookup(0, 0, 0, 1'b0, 0, 0, "R7 empty after reset");
  endtask

  task automatic test_hits();
    fill(10'h011, 3, 0, 1, 1'b0);
    fill(10'h022, 3, 1, 1, 1'b0);
    fill(10'h033, 3, 2, 1, 1'b0);
    fill(10'h044, 3, 3, 1, 1'b0);
    lookup(10'h011, 3, 0, 1'b1, 0, 1, "R3 way0");
    lookup(10'h022, 3, 3, 1'b1, 1, 1, "R1 way1 offset3");
    lookup(10'h033, 3, 1, 1'b1, 2, 1, "R3 way2");
    lookup(10'h044, 3, 2, 1'b1, 3, 1, "R1 way3 offset2");
  endtask

  task automatic test_misses();
    lookup(10'h055, 3, 0, 1'b0, 0, 0, "R4 unknown tag");
    lookup(10'h011, 5, 0, 1'b0, 0, 0, "R1 other set");
  endtask

  task automatic test_invalidate();
    fill(10'h033, 3, 2, 1, 1'b1);
    lookup(10'h033, 3, 1, 1'b0, 0, 0, "R5 stale tag cleared way");
    lookup(10'h044, 3, 0, 1'b1, 3, 1, "R8 neighbour untouched");
  endtask

  task automatic test_refill();
    fill(10'h066, 3, 1, 2, 1'b0);
    lookup(10'h022, 3, 0, 1'b0, 0, 0, "R8 old tag gone");
    lookup(10'h066, 3, 2, 1'b1, 1, 2, "R8 new line");
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(10'h077, 3, 0);
    @(negedge clk);
    req_addr = mk(10'h078, 3, 0);
    chk(req_ready === 1'b1, "R6 ready in missing tag phase", 64'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_hit === 1'b0 && tag_rd_en === 4'hF, "R6 miss with second tag phase",
        64'({rsp_valid, rsp_hit, tag_rd_en}), 64'h2F);
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_hit === 1'b0 && tag_rd_en === 4'h0, "R4 second miss",
        64'({rsp_valid, rsp_hit, tag_rd_en}), 64'h20);
  endtask

  task automatic test_stall();
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(10'h011, 3, 0);
    @(negedge clk);
    req_addr = mk(10'h044, 3, 1);
    chk(req_ready === 1'b0, "R6 ready low on matching tag phase", 64'(req_ready), 0);
    @(negedge clk);
    chk(req_ready === 1'b0 && data_way_en === 4'h1, "R6 held off in data phase",
        64'({req_ready, data_way_en}), 64'h1);
    @(negedge clk);
    chk(tag_rd_en === 4'h0 && rsp_hit === 1'b1 && rsp_data === word_of(3, 0, 1, 0),
        "R6 pending request not taken early", 64'({tag_rd_en, rsp_data}), 64'({4'h0, word_of(3, 0, 1, 0)}));
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag_rd_en === 4'hF, "R2 pending request taken when idle", 64'(tag_rd_en), 64'hF);
    @(negedge clk);
    chk(data_way_en === 4'h8, "R3 second lookup way3", 64'(data_way_en), 64'h8);
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_data === word_of(3, 3, 1, 1), "R3 second lookup data",
        64'(rsp_data), 64'(word_of(3, 3, 1, 1)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_hits();
    test_misses();
    test_invalidate();
    test_refill();
    test_back_to_back();
    test_stall();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule